// File: doc/BRIEF.md
# Live Memory Word Streamer

This block lets an external logic analyzer follow a handful of internal values while the chip runs. Four address slots name locations in an on-chip data memory. When a frame-sync pulse rises and the monitor is switched on, the block reads the four locations once. It then shifts the four words out, one after another, on a single test output. Every bit is timed by a slow test clock.

Each word goes out in its own fixed-length frame. A high marker bit comes first, so the analyzer can find the start of the word. The 32 data bits follow, most significant first, and two low guard cycles close the frame. Between bursts the output rests low. The frame-sync input may be asynchronous to the test clock. It is resynchronized, and only its rising edge counts.

Top module: `live_word_streamer`

## Requirements
- R1: After reset, `mon_out` is 0 and `mem_rd_en` is 0. `mon_out` stays 0 in every cycle in which no frame is being sent.
- R2: A rising edge of `frame_sync` starts a burst. Take the first rising `tclk` edge that samples `frame_sync` high as edge 1. The marker bit of word 0 is then on `mon_out` right after rising edge 9.
- R3: A `frame_sync` rising edge that arrives while `mon_en` is 0 starts no burst. No memory read is issued and `mon_out` stays 0.
- R4: Each frame lasts exactly 35 `tclk` cycles. Cycle 0 drives 1. Cycles 1 to 32 carry data bits 31 down to 0. Cycles 33 and 34 drive 0.
- R5: A burst is four frames sent back to back with no gap, 140 cycles in all. Word k is the word stored at the address in `word_addrs[8k+7:8k]`, and words go out in the order k = 0, 1, 2, 3.
- R6: All four words are captured before the first frame starts. Memory writes made while the burst is being sent do not change the bits sent.
- R7: A `frame_sync` rising edge that arrives while a burst is being fetched or sent is dropped. No second burst follows from it.
- R8: Each burst issues exactly four single-cycle reads, one per address slot, in slot order 0 to 3. The read data is taken to be valid one cycle after `mem_rd_en`.
- R9: Holding `frame_sync` high produces only one burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tclk | input | 1 | Test clock; times fetch and shifting |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Monitor enable; gates the start of a burst |
| frame_sync | input | 1 | Frame-sync request, asynchronous to `tclk` |
| word_addrs | input | 32 | Four 8-bit address slots; slot k in bits [8k+7:8k] |
| mem_rd_en | output | 1 | Read strobe to the data memory |
| mem_rd_addr | output | 8 | Read address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the strobe |
| mon_out | output | 1 | Serial monitor output |

## Verification
The bench targets four hazards. A design that read memory lazily, word by word, would send a word the bench has overwritten during the burst. A design that latched frame-sync as a level, or queued an edge that came in mid-burst, would send a second burst into what should be a quiet stretch. The vector set repeats an address and uses all-zero, all-one, single-MSB and alternating words, which exposes off-by-one bit ordering and missing guard cycles. An exact start-latency count catches any register added to or missing from the synchronizer or the fetch path.

// File: rtl/lws_pkg.sv
package lws_pkg;

    typedef enum logic {
        F_IDLE,
        F_RUN
    } fetch_state_e;

    // marker bit + data bits + guard cycles
    function automatic int frame_len(input int dw, input int guard);
        return 1 + dw + guard;
    endfunction

    // counter width for values 0..n-1, at least one bit
    function automatic int bits_for(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lws_sync_edge.sv
module lws_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic s_meta;
    logic s_stable;
    logic s_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_meta   <= 1'b0;
            s_stable <= 1'b0;
            s_prev   <= 1'b0;
        end else begin
            s_meta   <= async_in;
            s_stable <= s_meta;
            s_prev   <= s_stable;
        end
    end

    assign rise = s_stable & ~s_prev;

    // R9
    single_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/lws_fetch.sv
module lws_fetch
    import lws_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8,
    parameter int NW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [NW*AW-1:0] addrs,
    output logic            rd_en,
    output logic [AW-1:0]   rd_addr,
    input  logic [DW-1:0]   rd_data,
    output logic [NW*DW-1:0] words,
    output logic            busy,
    output logic            done
);
    localparam int SW = bits_for(NW + 1);
    localparam int CW = bits_for(NW);

    fetch_state_e  st;
    logic [SW-1:0] issue_cnt;
    logic          cap_v;
    logic [CW-1:0] cap_idx;

    assign rd_en = (st == F_RUN) && (issue_cnt < SW'(NW));
    assign busy  = (st == F_RUN) || done;

    always_comb begin
        rd_addr = '0;
        for (int k = 0; k < NW; k++) begin
            if (issue_cnt == SW'(k)) rd_addr = addrs[k*AW +: AW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= F_IDLE;
            issue_cnt <= '0;
            cap_v     <= 1'b0;
            cap_idx   <= '0;
            done      <= 1'b0;
            words     <= '0;
        end else begin
            done    <= 1'b0;
            cap_v   <= rd_en;
            cap_idx <= CW'(issue_cnt);
            case (st)
                F_IDLE: begin
                    if (start) begin
                        st        <= F_RUN;
                        issue_cnt <= '0;
                    end
                end
                F_RUN: begin
                    if (rd_en) issue_cnt <= issue_cnt + 1'b1;
                    if (cap_v) begin
                        words[cap_idx*DW +: DW] <= rd_data;
                        if (cap_idx == CW'(NW - 1)) begin
                            st   <= F_IDLE;
                            done <= 1'b1;
                        end
                    end
                end
                default: st <= F_IDLE;
            endcase
        end
    end

    // R8
    first_read_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (rd_en && rd_addr == $past(addrs[AW-1:0])));

    // R8
    done_after_capture_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(cap_v));

endmodule

// File: rtl/lws_shifter.sv
module lws_shifter
    import lws_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NW    = 4,
    parameter int GUARD = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [NW*DW-1:0] words,
    output logic            busy,
    output logic            ser
);
    localparam int FRAME = frame_len(DW, GUARD);
    localparam int CW    = bits_for(FRAME);
    localparam int IW    = bits_for(NW);

    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;
    logic [DW-1:0] cur;
    logic [DW-1:0] shifted;

    always_comb begin
        cur = '0;
        for (int k = 0; k < NW; k++) begin
            if (idx == IW'(k)) cur = words[k*DW +: DW];
        end
    end

    assign shifted = cur >> (CW'(DW) - cnt);

    always_comb begin
        ser = 1'b0;
        if (busy) begin
            if (cnt == '0)               ser = 1'b1;
            else if (cnt <= CW'(DW))     ser = shifted[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            idx  <= '0;
        end else if (load && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
            idx  <= '0;
        end else if (busy) begin
            if (cnt == CW'(FRAME - 1)) begin
                cnt <= '0;
                if (idx == IW'(NW - 1)) busy <= 1'b0;
                else                    idx  <= idx + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R4
    marker_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ser);

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ser);

    // R5
    burst_end_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == CW'(FRAME - 1) && idx == IW'(NW - 1)) |=> !busy);

endmodule

// File: rtl/live_word_streamer.sv
module live_word_streamer
    import lws_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 8,
    parameter int NW    = 4,
    parameter int GUARD = 2
) (
    input  logic            tclk,
    input  logic            rst,
    input  logic            mon_en,
    input  logic            frame_sync,
    input  logic [NW*AW-1:0] word_addrs,
    output logic            mem_rd_en,
    output logic [AW-1:0]   mem_rd_addr,
    input  logic [DW-1:0]   mem_rd_data,
    output logic            mon_out
);
    logic            sync_rise;
    logic            start;
    logic            fetch_busy;
    logic            fetch_done;
    logic            shift_busy;
    logic [NW*DW-1:0] held_words;

    lws_sync_edge u_sync (
        .clk      (tclk),
        .rst      (rst),
        .async_in (frame_sync),
        .rise     (sync_rise)
    );

    assign start = sync_rise && mon_en && !fetch_busy && !shift_busy;

    lws_fetch #(.DW(DW), .AW(AW), .NW(NW)) u_fetch (
        .clk     (tclk),
        .rst     (rst),
        .start   (start),
        .addrs   (word_addrs),
        .rd_en   (mem_rd_en),
        .rd_addr (mem_rd_addr),
        .rd_data (mem_rd_data),
        .words   (held_words),
        .busy    (fetch_busy),
        .done    (fetch_done)
    );

    lws_shifter #(.DW(DW), .NW(NW), .GUARD(GUARD)) u_shift (
        .clk   (tclk),
        .rst   (rst),
        .load  (fetch_done),
        .words (held_words),
        .busy  (shift_busy),
        .ser   (mon_out)
    );

    // R6
    no_read_while_sending_chk: assert property (@(posedge tclk) disable iff (rst)
        mem_rd_en |-> !shift_busy);

    // R7
    no_overlap_chk: assert property (@(posedge tclk) disable iff (rst)
        shift_busy |-> !fetch_busy);

    // R3
    enable_gate_chk: assert property (@(posedge tclk) disable iff (rst)
        $rose(mem_rd_en) |-> $past(mon_en));

endmodule

// File: tb/tb_live_word_streamer.sv
module tb_live_word_streamer;
    localparam int FRM   = 35;
    localparam int BURST = 4 * FRM;

    logic        tclk = 1'b0;
    logic        rst;
    logic        mon_en;
    logic        frame_sync;
    logic [31:0] word_addrs;
    logic        mem_rd_en;
    logic [7:0]  mem_rd_addr;
    logic [31:0] mem_rd_data;
    logic        mon_out;

    logic [31:0] mem [256];
    logic [7:0]  rd_log [64];
    int          rd_cnt = 0;
    int          n_chk  = 0;
    int          n_fail = 0;

    always #5 tclk = ~tclk;

    live_word_streamer dut (
        .tclk        (tclk),
        .rst         (rst),
        .mon_en      (mon_en),
        .frame_sync  (frame_sync),
        .word_addrs  (word_addrs),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .mon_out     (mon_out)
    );

    always_ff @(posedge tclk) begin
        if (mem_rd_en) begin
            mem_rd_data        <= mem[mem_rd_addr];
            rd_log[rd_cnt[5:0]] <= mem_rd_addr;
            rd_cnt             <= rd_cnt + 1;
        end
    end

    // vectors: address slots (slot 0 in low byte) and words to store there
    localparam logic [31:0] VEC_ADDR [4] = '{
        32'h03_02_01_00, 32'hFF_80_7F_10, 32'h44_21_44_09, 32'h00_FE_55_AA };
    localparam logic [127:0] VEC_DATA [4] = '{
        {32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0001},
        {32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h1234_5678, 32'hDEAD_BEEF},
        {32'hCAFE_F00D, 32'h0F0F_0F0F, 32'hCAFE_F00D, 32'h7FFF_FFFE},
        {32'h8000_0001, 32'hC3C3_3C3C, 32'h0000_8000, 32'hFFFF_0000} };

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // raises frame_sync at a negedge, then samples at negedges
    task automatic run_burst(input int extra_at, input bit hold, input int poke_at,
                             output logic [BURST-1:0] rx, output int lat);
        int n = 0;
        int k = 0;
        bit seen = 0;
        rx  = '0;
        lat = -1;
        @(negedge tclk);
        frame_sync = 1'b1;
        while (k < BURST && n < 300) begin
            @(negedge tclk);
            n++;
            if (!hold && n == 3) frame_sync = 1'b0;
            if (!seen && mon_out) begin
                seen = 1;
                lat  = n;
            end
            if (seen) begin
                rx[BURST-1-k] = mon_out;
                k++;
            end
            if (extra_at > 0 && k == extra_at)     frame_sync = 1'b1;
            if (extra_at > 0 && k == extra_at + 4) frame_sync = 1'b0;
            if (poke_at > 0 && k == poke_at) begin
                for (int s = 0; s < 4; s++)
                    mem[word_addrs[s*8 +: 8]] = ~mem[word_addrs[s*8 +: 8]];
            end
        end
    endtask

    task automatic check_frames(input logic [BURST-1:0] rx, input logic [127:0] exp,
                                input string tag);
        for (int w = 0; w < 4; w++) begin
            logic [FRM-1:0] got;
            logic [FRM-1:0] want;
            got  = rx[BURST-1-FRM*w -: FRM];
            want = {1'b1, exp[w*32 +: 32], 2'b00};
            check(got == want, tag, 64'(got), 64'(want));
        end
    endtask

    task automatic quiet_for(input int cycles, input string tag);
        int highs = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge tclk);
            if (mon_out) highs++;
        end
        check(highs == 0, tag, 64'(highs), 64'd0);
    endtask

    function automatic logic [127:0] snapshot();
        logic [127:0] v;
        for (int s = 0; s < 4; s++) v[s*32 +: 32] = mem[word_addrs[s*8 +: 8]];
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge tclk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [BURST-1:0] rx;
        logic [127:0]     exp;
        int               lat;
        int               base;

        for (int a = 0; a < 256; a++) mem[a] = 32'h1000_0000 + 32'(a * 7);
        rst        = 1'b1;
        mon_en     = 1'b0;
        frame_sync = 1'b0;
        word_addrs = '0;
        repeat (3) @(negedge tclk);
        rst = 1'b0;
        @(negedge tclk);
        // R1 reset state
        check(mon_out == 1'b0, "R1 reset mon_out", 64'(mon_out), 64'd0);
        check(mem_rd_en == 1'b0, "R1 reset rd_en", 64'(mem_rd_en), 64'd0);
        mon_en = 1'b1;

        // vector table: R2 R4 R5 R8
        for (int v = 0; v < 4; v++) begin
            word_addrs = VEC_ADDR[v];
            for (int s = 0; s < 4; s++)
                mem[VEC_ADDR[v][s*8 +: 8]] = VEC_DATA[v][s*32 +: 32];
            exp  = snapshot();
            base = rd_cnt;
            run_burst(0, 0, 0, rx, lat);
            check(lat == 9, "R2 start latency", 64'(lat), 64'd9);
            check_frames(rx, exp, "R4 R5 frame content");
            check(rd_cnt - base == 4, "R8 read count", 64'(rd_cnt - base), 64'd4);
            for (int s = 0; s < 4; s++)
                check(rd_log[(base + s) % 64] == VEC_ADDR[v][s*8 +: 8], "R8 read order",
                      64'(rd_log[(base + s) % 64]), 64'(VEC_ADDR[v][s*8 +: 8]));
            quiet_for(10, "R1 idle after burst");
        end

        // R6: overwrite memory while word 0 is on the wire
        word_addrs = VEC_ADDR[1];
        exp = snapshot();
        run_burst(0, 0, 10, rx, lat);
        check_frames(rx, exp, "R6 captured words");

        // R7: new edge mid-burst is dropped
        base = rd_cnt;
        exp  = snapshot();
        run_burst(50, 0, 0, rx, lat);
        check_frames(rx, exp, "R7 burst intact");
        quiet_for(40, "R7 no second burst");
        check(rd_cnt - base == 4, "R7 reads", 64'(rd_cnt - base), 64'd4);

        // R9: level held high gives one burst
        base = rd_cnt;
        run_burst(0, 1, 0, rx, lat);
        quiet_for(40, "R9 held sync one burst");
        check(rd_cnt - base == 4, "R9 reads", 64'(rd_cnt - base), 64'd4);
        frame_sync = 1'b0;
        repeat (4) @(negedge tclk);

        // R3: disabled monitor ignores the edge
        mon_en = 1'b0;
        base   = rd_cnt;
        frame_sync = 1'b1;
        repeat (3) @(negedge tclk);
        frame_sync = 1'b0;
        quiet_for(40, "R3 disabled quiet");
        check(rd_cnt - base == 0, "R3 no reads", 64'(rd_cnt - base), 64'd0);

        // R2: re-enabled, next edge works again
        mon_en = 1'b1;
        exp = snapshot();
        run_burst(0, 0, 0, rx, lat);
        check(lat == 9, "R2 latency after re-enable", 64'(lat), 64'd9);
        check_frames(rx, exp, "R5 after re-enable");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule